// File: doc/BRIEF.md
# Host Reset Request Qualifier

This block lets a host system power-cycle itself through the battery protection switches. The host pulls an active-low request line low. The block brings that line into the local clock domain. It then checks that the line stays low for a minimum qualification width, measured in timebase ticks. Only a request that reaches this width while the protection controller reports normal operation is accepted.

An accepted request raises a force-off output that overrides both the charge and the discharge switch enables. The output stays high for a fixed hold-off period, also counted in ticks, and then clears by itself. Clearing does not depend on the request line, so normal operation resumes with both switches on. A request line that is still low at release does not start a new cycle: the line must first return high to re-arm the block.

A `busy` flag is high whenever the block is not armed and idle. With the default parameters and a 1 ms tick, the qualification width is 34 ms and the hold-off is about one second.

Top module: `host_reset_qualifier`

## Requirements
- R1: While `rst_n` is low, and directly after it is released with the request line high, `force_off` and `busy` are 0.
- R2: With `normal_mode` high, a request line held low makes `force_off` rise once exactly `QUAL_TICKS` ticks have been counted with `busy` high and `force_off` low.
- R3: If the request line returns high before the qualification count completes, the count is discarded, `force_off` stays 0, and `busy` returns to 0.
- R4: While `normal_mode` is low, a low request line of any length leaves `busy` and `force_off` at 0.
- R5: If `normal_mode` falls during qualification, `busy` drops on the next clock edge. A later qualification starts its count again from zero and needs the full `QUAL_TICKS`.
- R6: `force_off` stays high for exactly `HOLD_TICKS` ticks and then falls, whatever the request line level. If the line is high at release, `busy` falls together with `force_off`.
- R7: Changes of the request line during the hold-off neither end nor lengthen it.
- R8: If the request line is still low when the hold-off ends, `busy` stays 1 and no new `force_off` occurs until the line goes high. `busy` then clears three clock edges after the line rises.
- R9: `force_off` is never high while `busy` is low.
- R10: The request line passes through a two-flop synchroniser. With `normal_mode` high, `busy` is still 0 two clock edges after the line falls and is 1 after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_pin_n | input | 1 | Active-low reset request line from the host, asynchronous to `clk` |
| normal_mode | input | 1 | High while the protection controller is in normal operation |
| tick | input | 1 | One-cycle timebase pulse that advances the width and hold-off counters |
| force_off | output | 1 | High forces both switch enables off |
| busy | output | 1 | High while qualifying, holding off, or waiting for the line to return high |

## Verification
The bench builds the block with `QUAL_TICKS` = 4 and `HOLD_TICKS` = 6, and drives a tick every third clock. With these values a whole qualification and hold-off cycle takes a few dozen clocks, so accept, abort, early release and re-arm can all be run back to back. They are also short enough that the bench can count each tick that the block spends qualifying and holding, and compare those counts with the exact parameter values rather than with time windows.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_QUAL  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_REARM = 2'd3
  } hrq_state_e;

  // Busy whenever the block is not sitting armed and idle.
  function automatic logic hrq_is_busy(hrq_state_e s);
    return s != ST_ARMED;
  endfunction

  // Only the hold-off state overrides the switch enables.
  function automatic logic hrq_forces(hrq_state_e s);
    return s == ST_HOLD;
  endfunction

  // A counter finishes on the tick that would bring it to its limit.
  function automatic logic hrq_last_tick(int unsigned cnt, int unsigned limit, logic step);
    return step && (cnt + 1 == limit);
  endfunction

endpackage

// File: rtl/hrq_sync.sv
module hrq_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hrq_tick_count.sv
module hrq_tick_count
  import hrq_pkg::*;
#(
  parameter int LIMIT = 4,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step = run && tick;
  assign done = hrq_last_tick(int'(cnt_q), LIMIT, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || done) cnt_q <= '0;
    else if (step)       cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/host_reset_qualifier.sv
module host_reset_qualifier
  import hrq_pkg::*;
#(
  parameter int QUAL_TICKS  = 34,
  parameter int HOLD_TICKS  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req_pin_n,
  input  logic normal_mode,
  input  logic tick,
  output logic force_off,
  output logic busy
);

  hrq_state_e state_q, state_d;
  logic       pin_sync;
  logic       pin_low;
  logic       qual_run, qual_clr, qual_done;
  logic       hold_run, hold_clr, hold_done;

  hrq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rst_req_pin_n),
    .q_sync  (pin_sync)
  );

  assign pin_low = ~pin_sync;

  // Width counter runs only while the request is still valid.
  assign qual_run = (state_q == ST_QUAL) && pin_low && normal_mode;
  assign qual_clr = (state_q != ST_QUAL);

  hrq_tick_count #(.LIMIT(QUAL_TICKS)) qual_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (qual_clr),
    .run   (qual_run),
    .tick  (tick),
    .done  (qual_done)
  );

  // Hold-off counter depends on nothing but the state.
  assign hold_run = (state_q == ST_HOLD);
  assign hold_clr = (state_q != ST_HOLD);

  hrq_tick_count #(.LIMIT(HOLD_TICKS)) hold_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .run   (hold_run),
    .tick  (tick),
    .done  (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: if (pin_low && normal_mode) state_d = ST_QUAL;
      ST_QUAL: begin
        if (!pin_low || !normal_mode) state_d = ST_ARMED;
        else if (qual_done)           state_d = ST_HOLD;
      end
      ST_HOLD:  if (hold_done) state_d = pin_low ? ST_REARM : ST_ARMED;
      ST_REARM: if (!pin_low)  state_d = ST_ARMED;
      default:  state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  assign force_off = hrq_forces(state_q);
  assign busy      = hrq_is_busy(state_q);

endmodule

// File: rtl/hrq_checker.sv
module hrq_checker (
  input logic clk,
  input logic rst_n,
  input logic normal_mode,
  input logic pin_low,
  input logic force_off,
  input logic busy,
  input logic qual_done,
  input logic hold_done
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!force_off && !busy));

  // R9
  force_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> busy);

  // R2
  force_from_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_off) |-> $past(qual_done));

  // R6
  release_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_off) |-> $past(hold_done));

  // R7
  hold_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off && !hold_done) |=> force_off);

  // R4
  start_needs_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(normal_mode) && $past(pin_low)));

endmodule

bind host_reset_qualifier hrq_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .normal_mode (normal_mode),
  .pin_low     (pin_low),
  .force_off   (force_off),
  .busy        (busy),
  .qual_done   (qual_done),
  .hold_done   (hold_done)
);

// File: tb/host_reset_qualifier_tb_top.sv
module host_reset_qualifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QT = 4;
  localparam int HT = 6;
  localparam int TD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic normal = 1'b1;
  logic tick = 1'b0;
  logic force_off, busy;

  int total = 0;
  int bad = 0;
  int q_seen = 0;
  int h_seen = 0;
  int inv_errs = 0;
  bit force_seen = 0;
  bit busy_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reset_qualifier #(.QUAL_TICKS(QT), .HOLD_TICKS(HT), .SYNC_STAGES(2)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_req_pin_n (pin_n),
    .normal_mode   (normal),
    .tick          (tick),
    .force_off     (force_off),
    .busy          (busy)
  );

  // Timebase: one pulse every TD clocks, changed on the falling edge.
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == TD - 1) ? 0 : div + 1;
      tick = (div == 0);
    end
  end

  // Observers sample just after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tick && busy && !force_off) q_seen++;
      if (tick && force_off) h_seen++;
      if (force_off) force_seen = 1;
      if (busy) busy_seen = 1;
      if (force_off && !busy) inv_errs++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_force(input logic v, output bit ok);
    ok = 0;
    for (int i = 0; i < 500; i++) begin
      step(1);
      if (force_off === v) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic t_reset();
    step(2);
    check("R1 force_off in reset", force_off, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    step(3);
    check("R1 force_off after reset", force_off, 0);
    check("R1 busy after reset", busy, 0);
  endtask

  task automatic t_latency();
    force_seen = 0;
    pin_n = 1'b0;
    step(2);
    check("R10 busy after two edges", busy, 0);
    step(1);
    check("R10 busy after third edge", busy, 1);
    pin_n = 1'b1;
    step(3);
    check("R3 busy after early release", busy, 0);
    check("R3 no force on short pulse", force_seen, 0);
  endtask

  task automatic t_short_pulse();
    force_seen = 0;
    pin_n = 1'b0;
    step((QT - 2) * TD);
    pin_n = 1'b1;
    step(5);
    check("R3 short pulse force", force_seen, 0);
    check("R3 short pulse busy", busy, 0);
  endtask

  task automatic t_not_normal();
    normal = 1'b0;
    busy_seen = 0;
    force_seen = 0;
    pin_n = 1'b0;
    step((QT + 3) * TD);
    check("R4 busy outside normal mode", busy_seen, 0);
    check("R4 force outside normal mode", force_seen, 0);
    pin_n = 1'b1;
    step(3);
    normal = 1'b1;
    step(1);
  endtask

  task automatic t_abort();
    bit ok;
    pin_n = 1'b0;
    step(3 + TD);
    normal = 1'b0;
    step(1);
    check("R5 busy drops with normal mode", busy, 0);
    force_seen = 0;
    step((QT + 2) * TD);
    check("R5 no force after abort", force_seen, 0);
    q_seen = 0;
    normal = 1'b1;
    wait_force(1'b1, ok);
    check("R5 accepted after restart", ok, 1);
    check("R5 restarted count length", q_seen, QT);
    pin_n = 1'b1;
    wait_force(1'b0, ok);
    step(3);
    check("R5 idle after cycle", busy, 0);
  endtask

  task automatic t_accept(input bit stay_low);
    bit ok;
    q_seen = 0;
    pin_n = 1'b0;
    wait_force(1'b1, ok);
    check("R2 request accepted", ok, 1);
    check("R2 qualification ticks", q_seen, QT);
    h_seen = 0;
    step(2);
    pin_n = 1'b1;
    step(TD);
    if (stay_low) pin_n = 1'b0;
    check("R7 force held through line change", force_off, 1);
    wait_force(1'b0, ok);
    check("R6 force released", ok, 1);
    check("R6 hold-off ticks", h_seen, HT);
    if (stay_low) begin
      check("R8 busy while line still low", busy, 1);
      force_seen = 0;
      step((QT + 3) * TD);
      check("R8 no retrigger while low", force_seen, 0);
      check("R8 busy held until line high", busy, 1);
      pin_n = 1'b1;
      step(2);
      check("R8 busy before re-arm", busy, 1);
      step(1);
      check("R8 re-armed after line high", busy, 0);
    end else begin
      check("R6 busy clears with release", busy, 0);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_short_pulse();
    t_accept(1'b0);
    t_not_normal();
    t_abort();
    t_accept(1'b1);
    check("R9 force without busy", inv_errs, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule